// File: doc/BRIEF.md
# Four-Way Instruction Cache with Split-Line Fetch

This block is the instruction store of a fetch unit. It holds instruction bytes together with five predecode bits per byte, in lines of 32 bytes kept in four ways. A fetch request returns 16 bytes and their predecode bits one clock after it is presented. The fetch address picks an 8-byte chunk of a line. Chunks 0 to 2 return two consecutive chunks of that line. Chunk 3 is a split fetch: it returns the top chunk of the addressed line followed by the bottom chunk of the next sequential line. Both halves resolve in the same clock. Sets with an even index and sets with an odd index live in two separate banks, so the two lines of a split fetch are always read in parallel.

Fetch lookup compares a linear tag. Each line also keeps a physical tag, which a write-snoop port compares in order to invalidate instructions that memory writes have made stale. Fetches never change the contents. A line is either valid or invalid. A miss reports the line address to refill. The refill arrives as four 8-byte beats, with the requested chunk first and the rest in wrap-around order. The line becomes valid when the fourth beat is written. Victims are chosen by a round-robin pointer kept for each set.

Top module: `icache_split_fetch`

## Requirements
- R1: After reset every line is invalid. `rsp_valid` and `rsp_hit` read 0 during reset, and every fetch misses until a fill has completed.
- R2: A request with `fetch_valid` high produces `rsp_valid` high exactly one clock later, and no response appears without a request. With `fetch_addr[4:3]` = c in {0,1,2}, `rsp_bytes` holds bytes 8c..8c+15 of the addressed line, with the lowest address in bits [7:0]. `fetch_addr[2:0]` is ignored.
- R3: With `fetch_addr[4:3]` = 3 the fetch is split. `rsp_bytes[63:0]` holds bytes 24..31 of line L and `rsp_bytes[127:64]` holds bytes 0..7 of line L+1. `rsp_hit` is 1 only when both lines hit. This holds when L is even, when L is odd, and when L is in the last set so that L+1 wraps to set 0 with the next tag.
- R4: On a miss, `rsp_miss_addr` gives the 32-byte-aligned address of the first missing line. That is L if line L misses, otherwise L+1 on a split fetch.
- R5: `rsp_pdc[5i+4:5i]` is the predecode field that was stored with byte i of `rsp_bytes`.
- R6: A fill is four beats on `fill_valid`. The first beat's `fill_addr` selects the line, and its bits [4:3] give the chunk it carries. Each later beat k carries chunk (first+k) mod 4, whatever its address and tag inputs hold. `fill_ptag` is taken from the first beat. The line misses until the fourth beat has been written.
- R7: The n-th fill into a set since reset replaces way n mod 4. A fifth fill into a set evicts the line written by the first one, and the other three lines stay.
- R8: A fetch hits only a valid line whose stored linear tag (address bits [31:12], set in bits [11:5]) matches. The physical tag plays no part in lookup, and fetches leave the contents unchanged.
- R9: A snoop whose `snoop_addr[11:5]` selects a set and whose bits [31:12] equal the physical tag of a valid line in that set invalidates that line, and only that line. A snoop that matches no physical tag has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch request |
| fetch_addr | input | 32 | Linear fetch address; [4:3] chunk, [2:0] ignored |
| rsp_valid | output | 1 | Response present, one clock after request |
| rsp_hit | output | 1 | All bytes requested were found |
| rsp_bytes | output | 128 | Fetched instruction bytes, lowest address in [7:0] |
| rsp_pdc | output | 80 | Predecode bits, five per returned byte |
| rsp_miss_addr | output | 32 | Aligned address of the line to refill |
| fill_valid | input | 1 | Fill beat present |
| fill_addr | input | 32 | Linear address of the line; [4:3] chunk on the first beat |
| fill_ptag | input | 20 | Physical tag of the line, used on the first beat |
| fill_data | input | 64 | Eight instruction bytes of the beat |
| fill_pdc | input | 40 | Predecode bits of the eight bytes |
| snoop_valid | input | 1 | Write snoop present |
| snoop_addr | input | 32 | Physical address written |

## Verification
Most internal faults reach the ports on the first fetch that touches the affected line, one clock after the request. A wrong valid bit, tag or round-robin pointer shows up as a wrong `rsp_hit` or `rsp_miss_addr`. A wrong chunk position or bank routing shows up as wrong bytes or predecode bits. Some faults stay hidden longer: a pointer that advances wrongly is only visible once a set has taken more fills than it has ways, and a misrouted snoop is only visible when that line is fetched again. The bench therefore keeps a behavioural model of every line and pointer and compares each response. It mixes directed cases with a long random run over a few crowded sets, including their wrap-around pair.

// File: rtl/icache_pkg.sv
package icache_pkg;
    // Default geometry shared by the cache and its sub-blocks.
    localparam int unsigned IC_ADDR_W      = 32;
    localparam int unsigned IC_LINE_BYTES  = 32;
    localparam int unsigned IC_CHUNK_BYTES = 8;
    localparam int unsigned IC_SETS        = 128;
    localparam int unsigned IC_WAYS        = 4;
    localparam int unsigned IC_PDC_BITS    = 5;

    // Refill sequencer state.
    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } fill_state_e;
endpackage

// File: rtl/icache_rr.sv
// Round-robin victim pointers, one per set.
// Assumes WAYS >= 2. The pointer of a set advances once per completed fill.
module icache_rr #(
    parameter int unsigned SETS = 128,
    parameter int unsigned WAYS = 4,
    localparam int unsigned IDX_W = $clog2(SETS),
    localparam int unsigned WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_set,
    output logic [WAY_W-1:0] victim,
    input  logic             adv,
    input  logic [IDX_W-1:0] adv_set
);
    logic [WAY_W-1:0] ptr_q [SETS];

    // Current victim of the set being opened.
    assign victim = ptr_q[rd_set];

    // Step the pointer of a set whose fill finished, wrapping after the last way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(SETS); i++) ptr_q[i] <= '0;
        end else if (adv) begin
            if (ptr_q[adv_set] == WAY_W'(WAYS - 1)) ptr_q[adv_set] <= '0;
            else                                    ptr_q[adv_set] <= ptr_q[adv_set] + 1'b1;
        end
    end
endmodule

// File: rtl/icache_fill.sv
// Refill sequencer. The first beat opens a line: it carries the requested
// chunk and takes the victim way. Later beats carry the following chunks in
// wrap-around order, and their own address bits are not used.
// Assumes CHUNKS is a power of two.
module icache_fill
    import icache_pkg::*;
#(
    parameter int unsigned LINE_W  = 27,
    parameter int unsigned CHUNKS  = 4,
    parameter int unsigned WAYS    = 4,
    localparam int unsigned CHUNK_W = $clog2(CHUNKS),
    localparam int unsigned WAY_W   = $clog2(WAYS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fill_valid,
    input  logic [LINE_W-1:0]  in_line,
    input  logic [CHUNK_W-1:0] in_chunk,
    input  logic [WAY_W-1:0]   victim,
    output logic               wr_en,
    output logic               wr_first,
    output logic               wr_last,
    output logic [LINE_W-1:0]  wr_line,
    output logic [CHUNK_W-1:0] wr_chunk,
    output logic [WAY_W-1:0]   wr_way,
    output logic               busy
);
    fill_state_e        state_q;
    logic [CHUNK_W-1:0] beat_q, start_q;
    logic [LINE_W-1:0]  line_q;
    logic [WAY_W-1:0]   way_q;

    assign busy = (state_q == FILL_BUSY);

    // Steer the beat to its line, chunk and way.
    always_comb begin
        wr_en    = fill_valid;
        wr_first = fill_valid && !busy;
        wr_last  = fill_valid && busy && (beat_q == CHUNK_W'(CHUNKS - 1));
        wr_line  = busy ? line_q : in_line;
        wr_chunk = busy ? start_q + beat_q : in_chunk;
        wr_way   = busy ? way_q : victim;
    end

    // Track the beat count and hold the line being refilled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_IDLE;
            beat_q  <= '0;
            start_q <= '0;
            line_q  <= '0;
            way_q   <= '0;
        end else if (fill_valid) begin
            if (!busy) begin
                state_q <= FILL_BUSY;
                beat_q  <= CHUNK_W'(1);
                start_q <= in_chunk;
                line_q  <= in_line;
                way_q   <= victim;
            end else begin
                beat_q <= beat_q + 1'b1;
                if (wr_last) state_q <= FILL_IDLE;
            end
        end
    end
endmodule

// File: rtl/icache_bank.sv
// One bank of sets: valid bits, linear and physical tags, instruction bytes
// and predecode bits. Lookup is combinational on the linear tag. Fills write
// one chunk per beat. A snoop clears the valid lines whose physical tag matches.
module icache_bank #(
    parameter int unsigned SETS_B      = 64,
    parameter int unsigned WAYS        = 4,
    parameter int unsigned TAG_W       = 20,
    parameter int unsigned LINE_BYTES  = 32,
    parameter int unsigned CHUNK_BYTES = 8,
    parameter int unsigned PDC_BITS    = 5,
    localparam int unsigned SET_W      = $clog2(SETS_B),
    localparam int unsigned WAY_W      = $clog2(WAYS),
    localparam int unsigned CHUNK_W    = $clog2(LINE_BYTES / CHUNK_BYTES),
    localparam int unsigned LINE_BITS  = LINE_BYTES * 8,
    localparam int unsigned PDC_LINE   = LINE_BYTES * PDC_BITS,
    localparam int unsigned CHUNK_BITS = CHUNK_BYTES * 8,
    localparam int unsigned CHUNK_PDC  = CHUNK_BYTES * PDC_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SET_W-1:0]      rd_set,
    input  logic [TAG_W-1:0]      rd_ltag,
    output logic                  rd_hit,
    output logic [LINE_BITS-1:0]  rd_data,
    output logic [PDC_LINE-1:0]   rd_pdc,
    input  logic                  wr_en,
    input  logic                  wr_first,
    input  logic                  wr_last,
    input  logic [SET_W-1:0]      wr_set,
    input  logic [WAY_W-1:0]      wr_way,
    input  logic [CHUNK_W-1:0]    wr_chunk,
    input  logic [TAG_W-1:0]      wr_ltag,
    input  logic [TAG_W-1:0]      wr_ptag,
    input  logic [CHUNK_BITS-1:0] wr_data,
    input  logic [CHUNK_PDC-1:0]  wr_pdc,
    input  logic                  snp_en,
    input  logic [SET_W-1:0]      snp_set,
    input  logic [TAG_W-1:0]      snp_ptag
);
    logic [WAYS-1:0]      valid_q [SETS_B];
    logic [TAG_W-1:0]     ltag_q  [SETS_B][WAYS];
    logic [TAG_W-1:0]     ptag_q  [SETS_B][WAYS];
    logic [LINE_BITS-1:0] data_q  [SETS_B][WAYS];
    logic [PDC_LINE-1:0]  pdc_q   [SETS_B][WAYS];
    logic [WAYS-1:0]      way_hit, snp_hit;

    // Per-way tag comparators for lookup and snoop.
    for (genvar w = 0; w < int'(WAYS); w++) begin : g_cmp
        assign way_hit[w] = valid_q[rd_set][w] && (ltag_q[rd_set][w] == rd_ltag);
        assign snp_hit[w] = snp_en && valid_q[snp_set][w] && (ptag_q[snp_set][w] == snp_ptag);
    end

    // Merge the single hitting way onto the read bus.
    always_comb begin
        rd_hit  = |way_hit;
        rd_data = '0;
        rd_pdc  = '0;
        for (int w = 0; w < int'(WAYS); w++) begin
            if (way_hit[w]) begin
                rd_data = rd_data | data_q[rd_set][w];
                rd_pdc  = rd_pdc | pdc_q[rd_set][w];
            end
        end
    end

    // Valid bits: cleared when a fill opens the line, set on its last beat, cleared by snoop hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(SETS_B); s++) valid_q[s] <= '0;
        end else begin
            if (wr_en && wr_first) valid_q[wr_set][wr_way] <= 1'b0;
            if (wr_en && wr_last)  valid_q[wr_set][wr_way] <= 1'b1;
            for (int w = 0; w < int'(WAYS); w++)
                if (snp_hit[w]) valid_q[snp_set][w] <= 1'b0;
        end
    end

    // Tags and payload, written by fill beats only.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_first) begin
                ltag_q[wr_set][wr_way] <= wr_ltag;
                ptag_q[wr_set][wr_way] <= wr_ptag;
            end
            data_q[wr_set][wr_way][wr_chunk*CHUNK_BITS +: CHUNK_BITS] <= wr_data;
            pdc_q[wr_set][wr_way][wr_chunk*CHUNK_PDC +: CHUNK_PDC]    <= wr_pdc;
        end
    end
endmodule

// File: rtl/icache_split_fetch.sv
// Read-only set-associative instruction cache with single-clock split-line
// fetch. Even and odd sets sit in separate banks, so lines L and L+1 are
// always read together. Responses are registered: one clock after the request.
// Assumes the set index sits inside the page offset, so linear and physical
// addresses select the same set.
module icache_split_fetch
    import icache_pkg::*;
#(
    parameter int unsigned ADDR_W      = IC_ADDR_W,
    parameter int unsigned LINE_BYTES  = IC_LINE_BYTES,
    parameter int unsigned CHUNK_BYTES = IC_CHUNK_BYTES,
    parameter int unsigned SETS        = IC_SETS,
    parameter int unsigned WAYS        = IC_WAYS,
    parameter int unsigned PDC_BITS    = IC_PDC_BITS,
    localparam int unsigned OFS_W      = $clog2(LINE_BYTES),
    localparam int unsigned IDX_W      = $clog2(SETS),
    localparam int unsigned TAG_W      = ADDR_W - OFS_W - IDX_W,
    localparam int unsigned LINE_W     = ADDR_W - OFS_W,
    localparam int unsigned CHUNKS     = LINE_BYTES / CHUNK_BYTES,
    localparam int unsigned CHUNK_W    = $clog2(CHUNKS),
    localparam int unsigned CHUNK_OFS  = $clog2(CHUNK_BYTES),
    localparam int unsigned CHUNK_BITS = CHUNK_BYTES * 8,
    localparam int unsigned CHUNK_PDC  = CHUNK_BYTES * PDC_BITS,
    localparam int unsigned FETCH_BITS = 2 * CHUNK_BITS,
    localparam int unsigned FETCH_PDC  = 2 * CHUNK_PDC,
    localparam int unsigned LINE_BITS  = LINE_BYTES * 8,
    localparam int unsigned PDC_LINE   = LINE_BYTES * PDC_BITS,
    localparam int unsigned BSET_W     = IDX_W - 1,
    localparam int unsigned WAY_W      = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fetch_valid,
    input  logic [ADDR_W-1:0]     fetch_addr,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic [FETCH_BITS-1:0] rsp_bytes,
    output logic [FETCH_PDC-1:0]  rsp_pdc,
    output logic [ADDR_W-1:0]     rsp_miss_addr,
    input  logic                  fill_valid,
    input  logic [ADDR_W-1:0]     fill_addr,
    input  logic [TAG_W-1:0]      fill_ptag,
    input  logic [CHUNK_BITS-1:0] fill_data,
    input  logic [CHUNK_PDC-1:0]  fill_pdc,
    input  logic                  snoop_valid,
    input  logic [ADDR_W-1:0]     snoop_addr
);
    logic [LINE_W-1:0]     line_a, line_b, miss_line, f_line;
    logic [CHUNK_W-1:0]    chunk, f_chunk;
    logic                  split, a_odd, hit_a, hit_b, fetch_hit;
    logic [BSET_W-1:0]     bk_set  [2];
    logic [TAG_W-1:0]      bk_tag  [2];
    logic                  bk_hit  [2];
    logic [LINE_BITS-1:0]  bk_data [2];
    logic [PDC_LINE-1:0]   bk_pdc  [2];
    logic [LINE_BITS-1:0]  data_a, data_b;
    logic [PDC_LINE-1:0]   pdc_a, pdc_b;
    logic [FETCH_BITS-1:0] sel_bytes;
    logic [FETCH_PDC-1:0]  sel_pdc;
    logic                  f_wr_en, f_first, fill_done, fill_busy;
    logic [WAY_W-1:0]      victim, fill_way;
    logic                  unused_bits;

    assign unused_bits = ^{fetch_addr[CHUNK_OFS-1:0], fill_addr[CHUNK_OFS-1:0], snoop_addr[OFS_W-1:0]};

    // Decode the fetch: line pair, chunk, split flag and bank routing.
    always_comb begin
        line_a = fetch_addr[ADDR_W-1:OFS_W];
        line_b = line_a + 1'b1;
        chunk  = fetch_addr[OFS_W-1:CHUNK_OFS];
        split  = (chunk == CHUNK_W'(CHUNKS - 1));
        a_odd  = line_a[0];
        bk_set[0] = a_odd ? line_b[IDX_W-1:1] : line_a[IDX_W-1:1];
        bk_tag[0] = a_odd ? line_b[LINE_W-1:IDX_W] : line_a[LINE_W-1:IDX_W];
        bk_set[1] = a_odd ? line_a[IDX_W-1:1] : line_b[IDX_W-1:1];
        bk_tag[1] = a_odd ? line_a[LINE_W-1:IDX_W] : line_b[LINE_W-1:IDX_W];
    end

    icache_rr #(.SETS(SETS), .WAYS(WAYS)) rr_i (
        .clk(clk), .rst_n(rst_n),
        .rd_set(fill_addr[OFS_W+IDX_W-1:OFS_W]), .victim(victim),
        .adv(fill_done), .adv_set(f_line[IDX_W-1:0])
    );

    icache_fill #(.LINE_W(LINE_W), .CHUNKS(CHUNKS), .WAYS(WAYS)) fill_i (
        .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid),
        .in_line(fill_addr[ADDR_W-1:OFS_W]), .in_chunk(fill_addr[OFS_W-1:CHUNK_OFS]),
        .victim(victim), .wr_en(f_wr_en), .wr_first(f_first), .wr_last(fill_done),
        .wr_line(f_line), .wr_chunk(f_chunk), .wr_way(fill_way), .busy(fill_busy)
    );

    // Bank 0 holds even sets, bank 1 odd sets.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        icache_bank #(
            .SETS_B(SETS / 2), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES),
            .CHUNK_BYTES(CHUNK_BYTES), .PDC_BITS(PDC_BITS)
        ) bank_i (
            .clk(clk), .rst_n(rst_n),
            .rd_set(bk_set[b]), .rd_ltag(bk_tag[b]), .rd_hit(bk_hit[b]),
            .rd_data(bk_data[b]), .rd_pdc(bk_pdc[b]),
            .wr_en(f_wr_en && (f_line[0] == 1'(b))), .wr_first(f_first), .wr_last(fill_done),
            .wr_set(f_line[IDX_W-1:1]), .wr_way(fill_way), .wr_chunk(f_chunk),
            .wr_ltag(f_line[LINE_W-1:IDX_W]), .wr_ptag(fill_ptag),
            .wr_data(fill_data), .wr_pdc(fill_pdc),
            .snp_en(snoop_valid && (snoop_addr[OFS_W] == 1'(b))),
            .snp_set(snoop_addr[OFS_W+IDX_W-1:OFS_W+1]),
            .snp_ptag(snoop_addr[ADDR_W-1:OFS_W+IDX_W])
        );
    end

    // Assemble the 16-byte window and the combined hit and miss result.
    always_comb begin
        hit_a  = a_odd ? bk_hit[1]  : bk_hit[0];
        hit_b  = a_odd ? bk_hit[0]  : bk_hit[1];
        data_a = a_odd ? bk_data[1] : bk_data[0];
        data_b = a_odd ? bk_data[0] : bk_data[1];
        pdc_a  = a_odd ? bk_pdc[1]  : bk_pdc[0];
        pdc_b  = a_odd ? bk_pdc[0]  : bk_pdc[1];
        fetch_hit = hit_a && (!split || hit_b);
        miss_line = hit_a ? line_b : line_a;
        if (split) begin
            sel_bytes = {data_b[CHUNK_BITS-1:0], data_a[LINE_BITS-1 -: CHUNK_BITS]};
            sel_pdc   = {pdc_b[CHUNK_PDC-1:0], pdc_a[PDC_LINE-1 -: CHUNK_PDC]};
        end else begin
            sel_bytes = data_a[chunk*CHUNK_BITS +: FETCH_BITS];
            sel_pdc   = pdc_a[chunk*CHUNK_PDC +: FETCH_PDC];
        end
    end

    // Register the response one clock after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_bytes     <= '0;
            rsp_pdc       <= '0;
            rsp_miss_addr <= '0;
        end else begin
            rsp_valid <= fetch_valid;
            rsp_hit   <= fetch_valid && fetch_hit;
            if (fetch_valid) begin
                rsp_bytes     <= sel_bytes;
                rsp_pdc       <= sel_pdc;
                rsp_miss_addr <= {miss_line, OFS_W'(0)};
            end
        end
    end
endmodule

// File: rtl/icache_split_fetch_chk.sv
// Protocol checker for icache_split_fetch, attached by bind. It keeps its own
// count of fill beats and its own record of whether any fill has finished.
module icache_split_fetch_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CHUNKS = 4,
    parameter int unsigned WAYS   = 4,
    localparam int unsigned CHUNK_W = $clog2(CHUNKS),
    localparam int unsigned WAY_W   = $clog2(WAYS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_valid,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [ADDR_W-1:0] rsp_miss_addr,
    input logic              fill_valid,
    input logic              fill_done,
    input logic              fill_busy,
    input logic [WAY_W-1:0]  fill_way
);
    logic [CHUNK_W-1:0] beats_q;
    logic               seen_fill_q;

    // Independent beat counter and completed-fill flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats_q     <= '0;
            seen_fill_q <= 1'b0;
        end else begin
            if (fill_valid) beats_q <= beats_q + 1'b1;
            if (fill_done) seen_fill_q <= 1'b1;
        end
    end

    p_no_hit_before_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_fill_q && rsp_valid) |-> !rsp_hit);

    p_rsp_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> rsp_valid);

    p_no_rsp_without_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !rsp_valid);

    p_miss_addr_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_miss_addr[4:0] == 5'd0));

    p_valid_on_fourth_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done == (fill_valid && (beats_q == CHUNK_W'(CHUNKS - 1))));

    p_victim_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_busy && $past(fill_busy)) |-> $stable(fill_way));
endmodule

bind icache_split_fetch icache_split_fetch_chk #(
    .ADDR_W(ADDR_W), .CHUNKS(CHUNKS), .WAYS(WAYS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss_addr(rsp_miss_addr), .fill_valid(fill_valid),
    .fill_done(fill_done), .fill_busy(fill_busy), .fill_way(fill_way)
);

// File: tb/icache_split_fetch_tb_top.sv
module icache_split_fetch_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSETS = 128;
    localparam int NWAYS = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fetch_valid, fill_valid, snoop_valid;
    logic [31:0]  fetch_addr, fill_addr, snoop_addr;
    logic [19:0]  fill_ptag;
    logic [63:0]  fill_data;
    logic [39:0]  fill_pdc;
    logic         rsp_valid, rsp_hit;
    logic [127:0] rsp_bytes;
    logic [79:0]  rsp_pdc;
    logic [31:0]  rsp_miss_addr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    icache_split_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_bytes(rsp_bytes), .rsp_pdc(rsp_pdc),
        .rsp_miss_addr(rsp_miss_addr), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_ptag(fill_ptag), .fill_data(fill_data), .fill_pdc(fill_pdc),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr)
    );

    int    vectors = 0;
    int    errors  = 0;
    string cur_req = "R1";
    bit    finished = 0;

    // Behavioural model of the cache contents.
    bit         mv  [NSETS][NWAYS];
    logic [19:0] ml [NSETS][NWAYS];
    logic [19:0] mp [NSETS][NWAYS];
    logic [7:0] md  [NSETS][NWAYS][32];
    logic [4:0] mpd [NSETS][NWAYS][32];
    int         rr  [NSETS];
    int         fbeat = 0;
    int         fstart, fway;
    logic [26:0] fline;

    logic         exp_valid, exp_hit;
    logic [31:0]  exp_miss;
    logic [127:0] exp_bytes;
    logic [79:0]  exp_pdc;

    function automatic logic [7:0] mem_byte(logic [26:0] l, int b);
        return 8'(int'(l[7:0]) * 7 + int'(l[15:8]) * 3 + int'(l[26:20]) + b * 13 + 5);
    endfunction

    function automatic logic [4:0] mem_pdc(logic [26:0] l, int b);
        return 5'(int'(l[4:0]) + int'(l[12:8]) + int'(l[26:22]) + b * 3);
    endfunction

    function automatic logic [19:0] ptag_of(logic [26:0] l);
        return l[26:7] ^ 20'hABCDE;
    endfunction

    function automatic int find_way(logic [26:0] l);
        int s = int'(l[6:0]);
        for (int w = 0; w < NWAYS; w++)
            if (mv[s][w] && ml[s][w] == l[26:7]) return w;
        return -1;
    endfunction

    task automatic idle_inputs();
        fetch_valid = 0; fetch_addr = '0;
        fill_valid = 0; fill_addr = '0; fill_ptag = '0; fill_data = '0; fill_pdc = '0;
        snoop_valid = 0; snoop_addr = '0;
    endtask

    task automatic compute_expect();
        logic [26:0] la, lb;
        int c, wa, wb, sa, sb;
        bit split;
        exp_valid = fetch_valid;
        exp_hit = 0; exp_miss = '0; exp_bytes = '0; exp_pdc = '0;
        if (fetch_valid) begin
            la = fetch_addr[31:5]; lb = la + 1; c = int'(fetch_addr[4:3]);
            split = (c == 3);
            wa = find_way(la); wb = find_way(lb);
            sa = int'(la[6:0]); sb = int'(lb[6:0]);
            exp_hit = (wa >= 0) && (!split || wb >= 0);
            exp_miss = (wa < 0) ? {la, 5'd0} : {lb, 5'd0};
            if (exp_hit) begin
                for (int i = 0; i < 16; i++) begin
                    if (!split) begin
                        exp_bytes[i*8 +: 8] = md[sa][wa][c*8 + i];
                        exp_pdc[i*5 +: 5]   = mpd[sa][wa][c*8 + i];
                    end else if (i < 8) begin
                        exp_bytes[i*8 +: 8] = md[sa][wa][24 + i];
                        exp_pdc[i*5 +: 5]   = mpd[sa][wa][24 + i];
                    end else begin
                        exp_bytes[i*8 +: 8] = md[sb][wb][i - 8];
                        exp_pdc[i*5 +: 5]   = mpd[sb][wb][i - 8];
                    end
                end
            end
        end
    endtask

    task automatic update_model();
        bit clr [NWAYS];
        int ss, s, ch;
        ss = int'(snoop_addr[11:5]);
        for (int w = 0; w < NWAYS; w++)
            clr[w] = snoop_valid && mv[ss][w] && (mp[ss][w] == snoop_addr[31:12]);
        if (fill_valid) begin
            if (fbeat == 0) begin
                fline = fill_addr[31:5]; fstart = int'(fill_addr[4:3]);
                s = int'(fline[6:0]); fway = rr[s];
                mv[s][fway] = 0; ml[s][fway] = fline[26:7]; mp[s][fway] = fill_ptag;
            end
            s = int'(fline[6:0]);
            ch = (fstart + fbeat) % 4;
            for (int j = 0; j < 8; j++) begin
                md[s][fway][ch*8 + j]  = fill_data[j*8 +: 8];
                mpd[s][fway][ch*8 + j] = fill_pdc[j*5 +: 5];
            end
            fbeat++;
            if (fbeat == 4) begin
                mv[s][fway] = 1; rr[s] = (rr[s] + 1) % NWAYS; fbeat = 0;
            end
        end
        for (int w = 0; w < NWAYS; w++)
            if (clr[w]) mv[ss][w] = 0;
    endtask

    task automatic check(string what, logic [127:0] act, logic [127:0] exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        vectors++;
        check("rsp_valid", 128'(rsp_valid), 128'(exp_valid));
        if (exp_valid) begin
            check("rsp_hit", 128'(rsp_hit), 128'(exp_hit));
            if (!exp_hit) check("rsp_miss_addr", 128'(rsp_miss_addr), 128'(exp_miss));
            else begin
                check("rsp_bytes", rsp_bytes, exp_bytes);
                check("rsp_pdc", 128'(rsp_pdc), 128'(exp_pdc));
            end
        end
    endtask

    // One clock: inputs already set at the falling edge.
    task automatic tick();
        compute_expect();
        @(posedge clk);
        update_model();
        @(negedge clk);
        compare();
        idle_inputs();
    endtask

    task automatic fetch(logic [26:0] l, int c, logic [2:0] low);
        fetch_valid = 1; fetch_addr = {l, 2'(c), low};
        tick();
    endtask

    // Four-beat fill, requested chunk first; later beats carry junk address and tag.
    task automatic fill_line(logic [26:0] l, int start, logic [19:0] pt, bit probe);
        for (int k = 0; k < 4; k++) begin
            int ch = (start + k) % 4;
            fill_valid = 1;
            fill_addr = (k == 0) ? {l, 2'(start), 3'b101} : {l ^ 27'h15A5, 2'(ch + 1), 3'b010};
            fill_ptag = (k == 0) ? pt : ~pt;
            for (int j = 0; j < 8; j++) begin
                fill_data[j*8 +: 8] = mem_byte(l, ch*8 + j);
                fill_pdc[j*5 +: 5]  = mem_pdc(l, ch*8 + j);
            end
            if (probe) begin
                fetch_valid = 1; fetch_addr = {l, 2'(start), 3'b000};
            end
            tick();
        end
    endtask

    task automatic snoop(logic [19:0] pt, logic [6:0] s);
        snoop_valid = 1; snoop_addr = {pt, s, 5'b00011};
        tick();
    endtask

    function automatic logic [26:0] mk(logic [19:0] t, logic [6:0] s);
        return {t, s};
    endfunction

    initial begin
        int sets_l [7] = '{0, 1, 2, 10, 11, 126, 127};
        logic [26:0] x, y;
        for (int s = 0; s < NSETS; s++) begin
            rr[s] = 0;
            for (int w = 0; w < NWAYS; w++) mv[s][w] = 0;
        end
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        vectors++;
        check("reset rsp_valid", 128'(rsp_valid), 128'(0));
        check("reset rsp_hit", 128'(rsp_hit), 128'(0));
        rst_n = 1;
        @(negedge clk);

        // R1, R4: empty cache misses and reports the line.
        x = mk(20'h00040, 7'd4);
        fetch(x, 0, 3'd0);
        fetch(x, 3, 3'd0);

        // R6: fill with chunk 2 first, probing the line on every beat.
        cur_req = "R6";
        fill_line(x, 2, ptag_of(x), 1);
        // R2, R5: normal fetches of each window, low address bits ignored.
        cur_req = "R2";
        fetch(x, 0, 3'd7);
        fetch(x, 1, 3'd3);
        cur_req = "R5";
        fetch(x, 2, 3'd1);

        // R4: split where the second line is missing, then where the first is.
        cur_req = "R4";
        fetch(x, 3, 3'd0);
        fetch(x - 1, 3, 3'd0);

        // R3: split from an even line, from an odd line, and across the set wrap.
        cur_req = "R3";
        fill_line(x + 1, 0, ptag_of(x + 1), 0);
        fetch(x, 3, 3'd0);
        fill_line(x + 2, 1, ptag_of(x + 2), 0);
        fetch(x + 1, 3, 3'd4);
        y = mk(20'h00077, 7'd127);
        fill_line(y, 3, ptag_of(y), 0);
        fetch(y, 3, 3'd0);
        fill_line(y + 1, 0, ptag_of(y + 1), 0);
        fetch(y, 3, 3'd0);

        // R8: linear tag decides the hit; same physical tag on two lines.
        cur_req = "R8";
        fill_line(mk(20'h00100, 7'd20), 0, 20'h0F0F0, 0);
        fetch(mk(20'h00200, 7'd20), 1, 3'd0);
        fill_line(mk(20'h00200, 7'd20), 3, 20'h0F0F0, 0);
        fetch(mk(20'h00100, 7'd20), 1, 3'd0);
        fetch(mk(20'h00200, 7'd20), 0, 3'd0);
        fetch(mk(20'h00200, 7'd20), 0, 3'd0);

        // R9: snoop with a linear tag does nothing; a physical match clears only its line.
        cur_req = "R9";
        snoop(20'h00100, 7'd20);
        fetch(mk(20'h00100, 7'd20), 0, 3'd0);
        snoop(ptag_of(x), 7'd4);
        fetch(x, 0, 3'd0);
        fetch(x + 1, 0, 3'd0);
        snoop(20'h0F0F0, 7'd20);
        fetch(mk(20'h00100, 7'd20), 0, 3'd0);
        fetch(mk(20'h00200, 7'd20), 0, 3'd0);

        // R7: five fills into one set; the fifth evicts the first.
        cur_req = "R7";
        for (int k = 0; k < 5; k++) begin
            fill_line(mk(20'h00300 + 20'(k), 7'd50), k % 4, ptag_of(mk(20'h00300 + 20'(k), 7'd50)), 0);
        end
        for (int k = 0; k < 5; k++) fetch(mk(20'h00300 + 20'(k), 7'd50), 1, 3'd0);

        // Mixed traffic over crowded sets, compared against the model each clock.
        cur_req = "R3";
        for (int it = 0; it < 1500; it++) begin
            int r = int'($urandom_range(0, 9));
            logic [26:0] l = mk(20'h00010 + 20'($urandom_range(0, 5)), 7'(sets_l[$urandom_range(0, 6)]));
            if (r < 6) begin
                fetch(l, int'($urandom_range(0, 3)), 3'($urandom));
            end else if (r < 8) begin
                int st = int'($urandom_range(0, 3));
                for (int k = 0; k < 4; k++) begin
                    int ch = (st + k) % 4;
                    logic [26:0] p = mk(20'h00010 + 20'($urandom_range(0, 5)), 7'(sets_l[$urandom_range(0, 6)]));
                    fill_valid = 1;
                    fill_addr = (k == 0) ? {l, 2'(st), 3'b000} : 32'($urandom);
                    fill_ptag = (k == 0) ? ptag_of(l) : 20'($urandom);
                    for (int j = 0; j < 8; j++) begin
                        fill_data[j*8 +: 8] = mem_byte(l, ch*8 + j);
                        fill_pdc[j*5 +: 5]  = mem_pdc(l, ch*8 + j);
                    end
                    if ($urandom_range(0, 1) == 1) begin
                        fetch_valid = 1; fetch_addr = {p, 2'($urandom), 3'b000};
                    end
                    if ($urandom_range(0, 3) == 0) begin
                        snoop_valid = 1; snoop_addr = {ptag_of(p), p[6:0], 5'b0};
                    end
                    tick();
                end
            end else begin
                snoop(ptag_of(l), l[6:0]);
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL %s watchdog: actual=running expected=done", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule